// File: doc/BRIEF.md
# Switch Port Lock Tracker

This block keeps the lock state of a switch or bridge that carries legacy locked read-modify-write sequences. It sees each request that arrives from upstream and each completion that returns from downstream. For every request it decides whether the request passes downstream now or is held. A locked read that arrives while no lock exists is forwarded, and the tracker then waits for its completion. A successful completion establishes the lock. The tracker keeps the requester ID of the owner, the locked address window (base and length) and the egress port the lock targets.

While the lock is held, the owner's traffic passes. Traffic from other requesters is held in a small queue in arrival order. The lock scope is sampled when the lock starts. In port scope, only traffic to the locked egress port is held. In switch scope, all traffic from other requesters is held. The owner releases the lock with a memory write inside the locked window. Two timers bound the wait for the completion and the time the lock is held. After any unlock, the queue drains one entry per cycle before new requests are accepted.

The states are UNLOCKED, LOCK_PENDING and LOCKED. The transitions are:
- lock request: UNLOCKED to LOCK_PENDING
- grant: LOCK_PENDING to LOCKED
- reject: LOCK_PENDING to UNLOCKED
- fail: LOCK_PENDING to UNLOCKED
- release: LOCKED to UNLOCKED
- expiry: LOCKED to UNLOCKED

Top module: `lock_tracker`

## Requirements
- R1: After reset, lock_state is UNLOCKED (0), req_ready is 1, and fwd_valid and all ev_* outputs are 0.
- R2: In UNLOCKED, an accepted request of req_kind 1 (locked read) is presented on fwd_* in the next cycle. The state then becomes LOCK_PENDING (lock_state 1). The tracker records the request's requester ID, address as window base, length, egress port and scope_wide as the lock attributes. Kinds 0 (read), 2 (write) and 3 (other) are forwarded in the next cycle and leave the state unchanged.
- R3: In LOCK_PENDING, req_ready is 0, so no later request is processed until the lock completion returns.
- R4: In LOCK_PENDING, a completion with cpl_status 0 (success) moves the state to LOCKED (2) and pulses ev_granted for one cycle.
- R5: In LOCK_PENDING, a completion with cpl_status 1 (unsupported request) or 2 (completer abort) returns the state to UNLOCKED and pulses ev_rejected.
- R6: In LOCK_PENDING, a completion with cpl_status 3 (error), or PEND_TIMEOUT cycles without a completion, returns the state to UNLOCKED and pulses ev_failed.
- R7: In LOCKED, requests from the owner's requester ID are forwarded in the next cycle, except locked reads.
- R8: In LOCKED, an owner write (kind 2) with address in [base, base+length) is forwarded, returns the state to UNLOCKED and pulses ev_released. An owner write outside that window is forwarded and the lock stays held.
- R9: In LOCKED with port scope (scope_wide was 0), a non-owner request to the locked egress port is held and one to another port is forwarded. With switch scope (scope_wide was 1), every non-owner request is held.
- R10: In LOCKED, a locked read from any requester is held and not forwarded, so at most one lock exists.
- R11: Held requests enter a queue of QDEPTH entries. In LOCKED, req_ready is 0 while the queue is full. After an unlock, the queue drains one entry per cycle in arrival order, with req_ready 0 until it is empty. A drained locked read starts a new lock.
- R12: After HOLD_TIMEOUT cycles in LOCKED without a release, the state returns to UNLOCKED and ev_expired pulses.
- R13: Completions that arrive outside LOCK_PENDING change neither the state nor any ev_* output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scope_wide | input | 1 | Scope for the next lock: 1 switch-wide, 0 egress port only |
| req_valid | input | 1 | Upstream request present |
| req_ready | output | 1 | Tracker accepts the request this cycle |
| req_kind | input | 2 | 0 read, 1 locked read, 2 write, 3 other |
| req_rid | input | RID_W | Requester ID |
| req_addr | input | ADDR_W | Request address |
| req_len | input | LEN_W | Request length |
| req_port | input | PORT_W | Egress port chosen by routing |
| cpl_valid | input | 1 | Completion returned from downstream |
| cpl_status | input | 2 | 0 success, 1 unsupported request, 2 completer abort, 3 error |
| fwd_valid | output | 1 | A request is forwarded downstream |
| fwd_kind | output | 2 | Forwarded request kind |
| fwd_rid | output | RID_W | Forwarded requester ID |
| fwd_addr | output | ADDR_W | Forwarded address |
| fwd_len | output | LEN_W | Forwarded length |
| fwd_port | output | PORT_W | Forwarded egress port |
| lock_state | output | 2 | 0 UNLOCKED, 1 LOCK_PENDING, 2 LOCKED |
| ev_granted | output | 1 | Lock granted pulse |
| ev_rejected | output | 1 | Lock rejected pulse |
| ev_failed | output | 1 | Lock failed pulse (error or timeout) |
| ev_released | output | 1 | Lock released by owner pulse |
| ev_expired | output | 1 | Lock hold timeout pulse |

## Verification
Directed sequences cover each lock outcome: success, unsupported request, completer abort, error status and silent timeout. Separate sequences take port scope and switch scope through owner and non-owner traffic, which separates the two blocking rules. Owner writes inside and outside the window show whether the release is tied to the owner and the region. A full queue under switch scope, resolved only by the hold timeout, exercises back-pressure and in-order draining. A long seeded random run mixes kinds, requester IDs, ports and stray completions, which catches interactions between draining, re-locking and timers.

// File: rtl/lkt_pkg.sv
`timescale 1ns/1ps
package lkt_pkg;
    typedef enum logic [1:0] {
        ST_UNLOCKED     = 2'd0,
        ST_LOCK_PENDING = 2'd1,
        ST_LOCKED       = 2'd2
    } lk_state_e;

    localparam logic [1:0] KIND_RD   = 2'd0;
    localparam logic [1:0] KIND_LKRD = 2'd1;
    localparam logic [1:0] KIND_WR   = 2'd2;

    localparam logic [1:0] CS_OK  = 2'd0;
    localparam logic [1:0] CS_UR  = 2'd1;
    localparam logic [1:0] CS_CA  = 2'd2;
    localparam logic [1:0] CS_ERR = 2'd3;
endpackage

// File: rtl/lkt_hold_fifo.sv
`timescale 1ns/1ps
module lkt_hold_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q;

    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CW'(DEPTH));
    assign dout  = mem[rd_q];

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_q] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) begin
                wr_q <= (wr_q == PW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
            end
            if (pop) begin
                rd_q <= (rd_q == PW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
            end
            unique case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // R11: the queue never takes an entry when full nor gives one when empty
    p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    p_no_underflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/lkt_region_cmp.sv
`timescale 1ns/1ps
module lkt_region_cmp #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 8
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [LEN_W-1:0]  len,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam int SW = ((ADDR_W > LEN_W) ? ADDR_W : LEN_W) + 1;

    logic [SW-1:0] lo, top, a;

    always_comb begin
        lo  = SW'(base);
        top = lo + SW'(len);
        a   = SW'(addr);
        hit = (a >= lo) && (a < top);
    end
endmodule

// File: rtl/lkt_stall_timer.sv
`timescale 1ns/1ps
module lkt_stall_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    assign expired = run && (cnt_q == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
        end else if (cnt_q != CW'(LIMIT - 1)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R6/R12: every timed stay starts counting from zero
    p_timer_fresh_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> (cnt_q == '0));
endmodule

// File: rtl/lock_tracker.sv
`timescale 1ns/1ps
module lock_tracker
    import lkt_pkg::*;
#(
    parameter int RID_W        = 4,
    parameter int ADDR_W       = 16,
    parameter int LEN_W        = 8,
    parameter int PORT_W       = 2,
    parameter int QDEPTH       = 4,
    parameter int PEND_TIMEOUT = 64,
    parameter int HOLD_TIMEOUT = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scope_wide,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [RID_W-1:0]  req_rid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic [PORT_W-1:0] req_port,
    input  logic              cpl_valid,
    input  logic [1:0]        cpl_status,
    output logic              fwd_valid,
    output logic [1:0]        fwd_kind,
    output logic [RID_W-1:0]  fwd_rid,
    output logic [ADDR_W-1:0] fwd_addr,
    output logic [LEN_W-1:0]  fwd_len,
    output logic [PORT_W-1:0] fwd_port,
    output logic [1:0]        lock_state,
    output logic              ev_granted,
    output logic              ev_rejected,
    output logic              ev_failed,
    output logic              ev_released,
    output logic              ev_expired
);
    localparam int ENT_W = 2 + RID_W + ADDR_W + LEN_W + PORT_W;

    lk_state_e st_q, st_d;

    logic [RID_W-1:0]  own_q;
    logic [ADDR_W-1:0] base_q;
    logic [LEN_W-1:0]  len_q;
    logic [PORT_W-1:0] port_q;
    logic              wide_q;

    logic              q_empty, q_full, q_push, q_pop;
    logic [ENT_W-1:0]  q_head, in_vec, cur_vec;

    logic [1:0]        c_kind;
    logic [RID_W-1:0]  c_rid;
    logic [ADDR_W-1:0] c_addr;
    logic [LEN_W-1:0]  c_len;
    logic [PORT_W-1:0] c_port;

    logic draining, accept, take, in_win, is_owner, blocked, pass;
    logic start_lock, release_lock, pend_to, hold_to;
    logic cpl_ok, cpl_rej, cpl_bad;

    // ---- source selection: queued entries drain before new arrivals ----
    assign draining  = (st_q == ST_UNLOCKED) && !q_empty;
    assign req_ready = ((st_q == ST_UNLOCKED) && q_empty) ||
                       ((st_q == ST_LOCKED) && !q_full);
    assign accept    = req_valid && req_ready;
    assign take      = draining || accept;

    assign in_vec  = {req_kind, req_rid, req_addr, req_len, req_port};
    assign cur_vec = draining ? q_head : in_vec;
    assign {c_kind, c_rid, c_addr, c_len, c_port} = cur_vec;

    lkt_region_cmp #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W)
    ) win_i (
        .base (base_q),
        .len  (len_q),
        .addr (c_addr),
        .hit  (in_win)
    );

    // ---- pass / hold decision ----
    assign is_owner = (c_rid == own_q);
    assign blocked  = (st_q == ST_LOCKED) &&
                      ((c_kind == KIND_LKRD) ||
                       (!is_owner && (wide_q || (c_port == port_q))));
    assign pass     = take && !blocked;
    assign q_push   = accept && blocked;
    assign q_pop    = draining;

    assign start_lock   = (st_q == ST_UNLOCKED) && take && (c_kind == KIND_LKRD);
    assign release_lock = (st_q == ST_LOCKED) && pass && is_owner &&
                          (c_kind == KIND_WR) && in_win;

    assign cpl_ok  = (st_q == ST_LOCK_PENDING) && cpl_valid && (cpl_status == CS_OK);
    assign cpl_rej = (st_q == ST_LOCK_PENDING) && cpl_valid &&
                     ((cpl_status == CS_UR) || (cpl_status == CS_CA));
    assign cpl_bad = (st_q == ST_LOCK_PENDING) &&
                     ((cpl_valid && (cpl_status == CS_ERR)) || (!cpl_valid && pend_to));

    lkt_hold_fifo #(
        .W     (ENT_W),
        .DEPTH (QDEPTH)
    ) hold_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (q_push),
        .din   (in_vec),
        .pop   (q_pop),
        .dout  (q_head),
        .empty (q_empty),
        .full  (q_full)
    );

    lkt_stall_timer #(.LIMIT(PEND_TIMEOUT)) pend_tmr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st_q == ST_LOCK_PENDING),
        .expired (pend_to)
    );

    lkt_stall_timer #(.LIMIT(HOLD_TIMEOUT)) hold_tmr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (st_q == ST_LOCKED),
        .expired (hold_to)
    );

    // ---- next state ----
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_UNLOCKED: begin
                if (start_lock) st_d = ST_LOCK_PENDING;
            end
            ST_LOCK_PENDING: begin
                if (cpl_ok)                  st_d = ST_LOCKED;
                else if (cpl_rej || cpl_bad) st_d = ST_UNLOCKED;
            end
            ST_LOCKED: begin
                if (release_lock || hold_to) st_d = ST_UNLOCKED;
            end
            default: st_d = ST_UNLOCKED;
        endcase
    end

    // ---- state register and lock attributes ----
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_UNLOCKED;
            own_q  <= '0;
            base_q <= '0;
            len_q  <= '0;
            port_q <= '0;
            wide_q <= 1'b0;
        end else begin
            st_q <= st_d;
            if (start_lock) begin
                own_q  <= c_rid;
                base_q <= c_addr;
                len_q  <= c_len;
                port_q <= c_port;
                wide_q <= scope_wide;
            end
        end
    end

    // ---- registered outputs ----
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fwd_valid   <= 1'b0;
            fwd_kind    <= '0;
            fwd_rid     <= '0;
            fwd_addr    <= '0;
            fwd_len     <= '0;
            fwd_port    <= '0;
            ev_granted  <= 1'b0;
            ev_rejected <= 1'b0;
            ev_failed   <= 1'b0;
            ev_released <= 1'b0;
            ev_expired  <= 1'b0;
        end else begin
            fwd_valid <= pass;
            if (pass) begin
                fwd_kind <= c_kind;
                fwd_rid  <= c_rid;
                fwd_addr <= c_addr;
                fwd_len  <= c_len;
                fwd_port <= c_port;
            end
            ev_granted  <= cpl_ok;
            ev_rejected <= cpl_rej;
            ev_failed   <= cpl_bad;
            ev_released <= release_lock;
            ev_expired  <= hold_to && !release_lock;
        end
    end

    assign lock_state = st_q;

    // ---- assertions ----
    p_pend_stall_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_LOCK_PENDING) |-> !req_ready);

    p_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_LOCK_PENDING) && cpl_valid && (cpl_status == CS_OK))
        |=> ((lock_state == 2'd2) && ev_granted));

    p_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_LOCK_PENDING) && cpl_valid &&
         ((cpl_status == CS_UR) || (cpl_status == CS_CA)))
        |=> ((lock_state == 2'd0) && ev_rejected));

    p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_released |-> (st_q == ST_UNLOCKED));

    p_second_lock_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_LOCKED) && req_valid && req_ready && (req_kind == KIND_LKRD))
        |=> !fwd_valid);

    p_drain_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_UNLOCKED) && !q_empty) |-> !req_ready);

    p_stray_cpl_r13: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q != ST_LOCK_PENDING) && cpl_valid)
        |=> !(ev_granted || ev_rejected || ev_failed));
endmodule

// File: tb/lock_tracker_tb.sv
`timescale 1ns/1ps
module lock_tracker_tb_top;
    localparam int RID_W  = 4;
    localparam int ADDR_W = 16;
    localparam int LEN_W  = 8;
    localparam int PORT_W = 2;
    localparam int QD     = 4;
    localparam int PT     = 16;
    localparam int HT     = 48;

    typedef struct packed {
        logic [1:0]        k;
        logic [RID_W-1:0]  r;
        logic [ADDR_W-1:0] a;
        logic [LEN_W-1:0]  l;
        logic [PORT_W-1:0] p;
    } ent_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scope_wide = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [1:0] req_kind = '0;
    logic [RID_W-1:0] req_rid = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic [PORT_W-1:0] req_port = '0;
    logic cpl_valid = 1'b0;
    logic [1:0] cpl_status = '0;
    logic fwd_valid;
    logic [1:0] fwd_kind;
    logic [RID_W-1:0] fwd_rid;
    logic [ADDR_W-1:0] fwd_addr;
    logic [LEN_W-1:0] fwd_len;
    logic [PORT_W-1:0] fwd_port;
    logic [1:0] lock_state;
    logic ev_granted, ev_rejected, ev_failed, ev_released, ev_expired;

    always #4 clk = ~clk;

    lock_tracker #(
        .RID_W(RID_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PORT_W(PORT_W),
        .QDEPTH(QD), .PEND_TIMEOUT(PT), .HOLD_TIMEOUT(HT)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .scope_wide(scope_wide),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_rid(req_rid), .req_addr(req_addr), .req_len(req_len), .req_port(req_port),
        .cpl_valid(cpl_valid), .cpl_status(cpl_status),
        .fwd_valid(fwd_valid), .fwd_kind(fwd_kind), .fwd_rid(fwd_rid),
        .fwd_addr(fwd_addr), .fwd_len(fwd_len), .fwd_port(fwd_port),
        .lock_state(lock_state), .ev_granted(ev_granted), .ev_rejected(ev_rejected),
        .ev_failed(ev_failed), .ev_released(ev_released), .ev_expired(ev_expired)
    );

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    int   m_st = 0;
    logic [RID_W-1:0]  m_own = '0;
    logic [ADDR_W-1:0] m_base = '0;
    logic [LEN_W-1:0]  m_len = '0;
    logic [PORT_W-1:0] m_port = '0;
    bit   m_wide = 0;
    int   pcnt = 0;
    int   hcnt = 0;
    ent_t mq[$];

    task automatic chk(bit ok, string tag, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit in_window(logic [ADDR_W-1:0] a);
        return (int'(a) >= int'(m_base)) && (int'(a) < int'(m_base) + int'(m_len));
    endfunction

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // One clock cycle: drive, compare ready, predict, compare registered outputs.
    task automatic cyc(bit v, ent_t in, bit sc, bit cv, logic [1:0] cs);
        bit   m_rdy, drain, acc, take, own, blk, pexp, hexp, rel, e_fv;
        ent_t c;
        int   ns;
        logic [4:0] e_ev;
        string rule;
        @(negedge clk);
        req_valid = v; req_kind = in.k; req_rid = in.r; req_addr = in.a;
        req_len = in.l; req_port = in.p; scope_wide = sc;
        cpl_valid = cv; cpl_status = cs;
        #1;
        m_rdy = (m_st == 0 && mq.size() == 0) || (m_st == 2 && mq.size() < QD);
        chk(req_ready == m_rdy, (m_st == 1) ? "R3" : "R11", "req_ready", req_ready, m_rdy);

        drain = (m_st == 0) && (mq.size() > 0);
        acc   = v && m_rdy;
        c     = drain ? mq[0] : in;
        take  = drain || acc;
        own   = (c.r == m_own);
        blk   = (m_st == 2) && ((c.k == 2'd1) || (!own && (m_wide || c.p == m_port)));
        pexp  = (m_st == 1) && (pcnt == PT - 1);
        hexp  = (m_st == 2) && (hcnt == HT - 1);
        e_fv  = take && !blk;
        e_ev  = '0;
        ns    = m_st;
        rel   = 0;
        rule  = (cv && m_st != 1) ? "R13" : "R2";
        if (drain) begin
            void'(mq.pop_front());
            rule = "R11";
        end
        if (m_st == 0) begin
            if (take && c.k == 2'd1) begin
                ns = 1; m_own = c.r; m_base = c.a; m_len = c.l; m_port = c.p; m_wide = sc;
                rule = "R2";
            end
        end else if (m_st == 1) begin
            if (cv) begin
                if (cs == 2'd0) begin ns = 2; e_ev[4] = 1; rule = "R4"; end
                else if (cs == 2'd3) begin ns = 0; e_ev[2] = 1; rule = "R6"; end
                else begin ns = 0; e_ev[3] = 1; rule = "R5"; end
            end else if (pexp) begin
                ns = 0; e_ev[2] = 1; rule = "R6";
            end
        end else begin
            if (acc && blk) begin
                mq.push_back(c);
                rule = (c.k == 2'd1) ? "R10" : "R9";
            end else if (acc) begin
                rule = own ? ((c.k == 2'd2) ? "R8" : "R7") : "R9";
                if (own && c.k == 2'd2 && in_window(c.a)) begin
                    rel = 1; ns = 0; e_ev[1] = 1;
                end
            end
            if (!rel && hexp) begin
                ns = 0; e_ev[0] = 1; rule = "R12";
            end
        end
        pcnt = (m_st == 1) ? pcnt + 1 : 0;
        hcnt = (m_st == 2) ? hcnt + 1 : 0;
        m_st = ns;

        @(posedge clk);
        #1;
        chk(fwd_valid == e_fv, rule, "fwd_valid", fwd_valid, e_fv);
        if (e_fv && fwd_valid) begin
            chk({fwd_kind, fwd_rid, fwd_addr, fwd_len, fwd_port} == c, rule, "fwd payload",
                {fwd_kind, fwd_rid, fwd_addr, fwd_len, fwd_port}, c);
        end
        chk(lock_state == 2'(ns), rule, "lock_state", lock_state, ns);
        chk({ev_granted, ev_rejected, ev_failed, ev_released, ev_expired} == e_ev, rule,
            "events", {ev_granted, ev_rejected, ev_failed, ev_released, ev_expired}, e_ev);
    endtask

    function automatic ent_t mk(logic [1:0] k, int r, int a, int l, int p);
        ent_t e;
        e.k = k; e.r = RID_W'(r); e.a = ADDR_W'(a); e.l = LEN_W'(l); e.p = PORT_W'(p);
        return e;
    endfunction

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc(0, '0, 0, 0, 2'd0);
    endtask

    task automatic send(ent_t e, bit sc);
        cyc(1, e, sc, 0, 2'd0);
    endtask

    task automatic cpl(logic [1:0] s);
        cyc(0, '0, 0, 1, s);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        // R1: reset values
        chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
        chk(fwd_valid == 1'b0, "R1", "fwd_valid", fwd_valid, 0);
        chk(lock_state == 2'd0, "R1", "lock_state", lock_state, 0);
        chk({ev_granted, ev_rejected, ev_failed, ev_released, ev_expired} == 5'd0, "R1",
            "events", {ev_granted, ev_rejected, ev_failed, ev_released, ev_expired}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        idle(2);

        // R2, R3, R4: port-scoped lock by requester 1 on port 2, window 0x100..0x13f
        send(mk(2'd1, 1, 'h100, 'h40, 2), 0);
        send(mk(2'd0, 3, 'h200, 4, 1), 0);     // R3: refused while pending
        idle(2);
        cpl(2'd0);                              // R4
        // R9 port scope, R7 owner, R10 second lock, R8 outside/inside window
        send(mk(2'd0, 3, 'h110, 4, 2), 0);     // held
        send(mk(2'd2, 3, 'h120, 4, 1), 0);     // passes (other port)
        send(mk(2'd0, 1, 'h104, 4, 2), 0);     // owner read passes
        send(mk(2'd1, 1, 'h108, 4, 2), 0);     // locked read held
        send(mk(2'd2, 2, 'h130, 4, 2), 0);     // held
        send(mk(2'd2, 1, 'h140, 4, 2), 0);     // owner write just past window: stays locked
        send(mk(2'd2, 1, 'h13f, 4, 2), 0);     // owner write at last byte: release
        idle(2);                                // R11 drain: read, then locked read starts lock
        cpl(2'd0);
        idle(1);
        send(mk(2'd2, 1, 'h108, 4, 2), 0);     // release, then last queued entry drains
        idle(3);

        // R5, R6 lock outcomes; R13 stray completion
        cpl(2'd0);                              // R13
        send(mk(2'd1, 4, 'h300, 8, 0), 0); cpl(2'd1);
        send(mk(2'd1, 4, 'h300, 8, 0), 0); cpl(2'd2);
        send(mk(2'd1, 4, 'h300, 8, 0), 0); cpl(2'd3);
        send(mk(2'd1, 4, 'h300, 8, 0), 0); idle(PT + 2);

        // R9 switch scope, R11 full queue, R12 hold timeout
        send(mk(2'd1, 5, 'h400, 'h10, 3), 1); cpl(2'd0);
        for (int i = 0; i < QD + 1; i++) send(mk(2'd0, 6 + i, 'h500 + i, 4, i % 4), 1);
        send(mk(2'd2, 5, 'h404, 4, 3), 1);     // owner also stalled by full queue
        idle(HT + QD + 2);

        // randomized mix
        for (int i = 0; i < 4000; i++) begin
            ent_t e;
            int   pick;
            bit   v, cv;
            logic [1:0] cs;
            pick = $urandom_range(0, 99);
            e.k = (pick < 12) ? 2'd1 : (pick < 45) ? 2'd2 : (pick < 95) ? 2'd0 : 2'd3;
            e.r = RID_W'($urandom_range(0, 3));
            e.a = ADDR_W'('h100 + $urandom_range(0, 'h7f));
            e.l = LEN_W'($urandom_range('h10, 'h60));
            e.p = PORT_W'($urandom_range(0, 3));
            v   = ($urandom_range(0, 99) < 60);
            cv  = (m_st == 1) ? ($urandom_range(0, 7) == 0) : ($urandom_range(0, 19) == 0);
            cs  = ($urandom_range(0, 9) < 6) ? 2'd0 : 2'($urandom_range(1, 3));
            cyc(v, e, $urandom_range(0, 1) == 1, cv, cs);
        end
        idle(HT + QD + PT + 4);

        summary();
        $finish;
    end
endmodule